// File: doc/BRIEF.md
# Independent-clock watchdog timer

This block guards a system against a program that hangs or runs away. An up-counter runs on its own slow clock. That clock comes from a separate oscillator, nominally 250 kHz, and has no relation to the system clock. Software enables the counter and must restart it from zero at regular intervals. If the counter ever wraps past its top value, the block raises a reset request for the whole chip.

A runaway program could otherwise disable the watchdog by accident. To prevent this, every control write must be preceded by a two-byte key sequence. A sticky status flag lets software tell a watchdog-caused reset apart from a power-on or pin reset.

Signals cross between the two clock domains as follows:
- The enable level is synchronised into the slow domain.
- Clear requests cross as toggles.
- Overflow events come back as toggles and are stretched into a reset pulse of fixed length.

Top module: `slowclk_watchdog`

## Requirements
- R1: While and after the external reset `sys_rst_n` is low, `enable_o`, `wd_flag_o` and `rst_req_o` are 0.
- R2: A write to the control address (1) while the block is locked has no effect on `enable_o` and starts no counting.
- R3: Writing 0x55 and then, as the very next write, 0xAA to the unlock address (0) unlocks the block. The next control write is then accepted, and its bit 7 becomes `enable_o`.
- R4: After one accepted control write the block is locked again, so a further control write without a new key sequence is ignored.
- R5: The key sequence fails, and the following control write is ignored, if the second key byte is anything other than 0xAA or if any other write comes between the two key bytes.
- R6: Once enabled, the counter of CNT_W bits counts slow-clock edges from 0. When it wraps, `rst_req_o` rises. This happens no earlier than 2^CNT_W slow-clock periods after the enabling write, plus a few synchroniser cycles.
- R7: Each overflow holds `rst_req_o` high for exactly RST_HOLD (default 4) system clocks.
- R8: An overflow clears `enable_o`, which stops further overflows, and sets `wd_flag_o` (status address 2, bit 0) in the same cycle that `rst_req_o` rises. The flag stays set afterwards.
- R9: An accepted control write with bit 0 set restarts the counter from 0. The clear bit is self-clearing, so repeated clears keep `rst_req_o` low indefinitely.
- R10: Writing a status byte with bit 0 = 0 clears `wd_flag_o`; writing bit 0 = 1 leaves it unchanged. Status writes need no key.
- R11: The external reset clears `wd_flag_o` even when it is set.
- R12: An accepted control write with bit 7 = 0 stops and zeroes the counter, so no reset request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | External hardware reset, active low, asynchronous |
| wd_clk | input | 1 | Independent slow oscillator clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 unlock, 1 control, 2 status |
| wr_data | input | 8 | Write data |
| enable_o | output | 1 | Current enable bit of the control register |
| wd_flag_o | output | 1 | Sticky flag: last reset came from the watchdog |
| rst_req_o | output | 1 | Reset request to the system, RST_HOLD clocks long |

## Verification
Register effects (`enable_o`, `wd_flag_o`, the lock state) are due one system clock after the write edge. The bench therefore drives each write on a falling edge and samples on the falling edge after the capture edge.

Overflow crosses two synchronisers, so its timing is only known within a window. The window has two parts:
- the enable sync plus 2^CNT_W slow periods, about 66–68 slow cycles;
- the return sync plus the pulse register, 3–4 system clocks.

The bench counts system cycles from the enabling or clearing write and accepts a narrow window around that figure.

The pulse width and the "no reset" cases are counted cycle by cycle over runs longer than one full count period.

// File: rtl/slowclk_watchdog.sv
module slowclk_watchdog #(
  parameter int CNT_W       = 16,
  parameter int RST_HOLD    = 4,
  parameter int ADDR_W      = 2,
  parameter int ADDR_UNLOCK = 0,
  parameter int ADDR_CTRL   = 1,
  parameter int ADDR_STATUS = 2,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              wd_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              enable_o,
  output logic              wd_flag_o,
  output logic              rst_req_o
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  typedef enum logic [1:0] {LOCKED, HALF, OPEN} lock_t;

  lock_t             lock_q;
  logic              clr_tgl;
  logic [2:0]        ovf_s;
  logic              ovf_evt;
  logic [HOLD_W-1:0] hold_q;

  logic [1:0]        en_s;
  logic [2:0]        clr_s;
  logic              clr_evt;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_tgl;

  wire wr_unl  = wr_en && (wr_addr == ADDR_W'(ADDR_UNLOCK));
  wire wr_ctl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  wire wr_sts  = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS));
  wire ctrl_ok = wr_ctl && (lock_q == OPEN);

  assign ovf_evt   = ovf_s[2] ^ ovf_s[1];
  assign clr_evt   = clr_s[2] ^ clr_s[1];
  assign rst_req_o = (hold_q != '0);

  // system domain: key sequence
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)             lock_q <= LOCKED;
    else if (ovf_evt)           lock_q <= LOCKED;
    else if (wr_unl) begin
      if (wr_data == KEY_A)                          lock_q <= HALF;
      else if (lock_q == HALF && wr_data == KEY_B)   lock_q <= OPEN;
      else                                           lock_q <= LOCKED;
    end
    else if (wr_ctl)                                 lock_q <= LOCKED;
    else if (wr_sts && lock_q == HALF)               lock_q <= LOCKED;
  end

  // system domain: control, status, reset pulse
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      enable_o  <= 1'b0;
      clr_tgl   <= 1'b0;
      wd_flag_o <= 1'b0;
      ovf_s     <= '0;
      hold_q    <= '0;
    end else begin
      ovf_s <= {ovf_s[1:0], ovf_tgl};
      if (ovf_evt) begin
        enable_o  <= 1'b0;
        wd_flag_o <= 1'b1;
        hold_q    <= HOLD_W'(RST_HOLD);
      end else begin
        if (hold_q != '0) hold_q <= hold_q - HOLD_W'(1);
        if (ctrl_ok) begin
          enable_o <= wr_data[7];
          if (wr_data[0]) clr_tgl <= ~clr_tgl;
        end
        if (wr_sts && !wr_data[0]) wd_flag_o <= 1'b0;
      end
    end
  end

  // slow domain: synchronisers and counter
  always_ff @(posedge wd_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_s    <= '0;
      clr_s   <= '0;
      cnt_q   <= '0;
      ovf_tgl <= 1'b0;
    end else begin
      en_s  <= {en_s[0], enable_o};
      clr_s <= {clr_s[1:0], clr_tgl};
      if (!en_s[1] || clr_evt)  cnt_q <= '0;
      else if (cnt_q == CNT_TOP) begin
        cnt_q   <= '0;
        ovf_tgl <= ~ovf_tgl;
      end
      else                      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  locked_write_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_ctl && lock_q != OPEN && !ovf_evt) |=> $stable(enable_o));

  // R4
  relock_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ctrl_ok |=> (lock_q == LOCKED));

  // R7
  pulse_len_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(rst_req_o) |=> rst_req_o);

  // R8
  cause_flag_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(rst_req_o) |-> (wd_flag_o && !enable_o));

  // R10
  flag_keep_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_sts && wr_data[0] && !ovf_evt) |=> $stable(wd_flag_o));

  // R6
  ovf_to_req_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ovf_evt |=> rst_req_o);
endmodule

// File: tb/slowclk_watchdog_test.sv
`timescale 1ns/1ps
module slowclk_watchdog_test;
  localparam int W = 6;
  localparam int HOLD = 4;
  localparam int LO = 190;
  localparam int HI = 220;

  logic sys_clk = 1'b0, wd_clk = 1'b0, sys_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic enable_o, wd_flag_o, rst_req_o;
  int checks = 0, errors = 0;
  bit done = 0;

  slowclk_watchdog #(.CNT_W(W), .RST_HOLD(HOLD)) uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable_o(enable_o), .wd_flag_o(wd_flag_o), .rst_req_o(rst_req_o));

  always #10 sys_clk = ~sys_clk;
  initial begin #7; forever #30 wd_clk = ~wd_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge sys_clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge sys_clk); wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
  endtask

  task automatic idle(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk);
      if (rst_req_o) hits++;
    end
  endtask

  task automatic until_req(output int n);
    n = 0;
    while (!rst_req_o && n < 400) begin
      @(negedge sys_clk); n++;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, n, len;
    repeat (5) @(negedge sys_clk);
    chk(!enable_o && !wd_flag_o && !rst_req_o, "R1 reset state", {enable_o, wd_flag_o, rst_req_o}, 0);
    sys_rst_n = 1'b1;
    @(negedge sys_clk);
    chk(!enable_o && !wd_flag_o && !rst_req_o, "R1 after release", {enable_o, wd_flag_o, rst_req_o}, 0);

    wr(2'd1, 8'h80);
    chk(enable_o == 1'b0, "R2 locked write", enable_o, 0);
    idle(260, h);
    chk(h == 0, "R2 no count", h, 0);

    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 8'h55); wr(2'd0, 8'(d)); wr(2'd1, 8'h80);
      chk(enable_o == (d == 8'hAA), (d == 8'hAA) ? "R3 unlock" : "R5 bad key", enable_o, d == 8'hAA);
      if (enable_o) begin
        unlock(); wr(2'd1, 8'h00);
        chk(enable_o == 1'b0, "R12 disable", enable_o, 0);
      end
    end

    wr(2'd0, 8'h55); wr(2'd2, 8'h01); wr(2'd0, 8'hAA); wr(2'd1, 8'h80);
    chk(enable_o == 1'b0, "R5 interrupted key", enable_o, 0);

    unlock(); wr(2'd1, 8'h80);
    chk(enable_o == 1'b1, "R3 enable", enable_o, 1);
    wr(2'd1, 8'h00);
    chk(enable_o == 1'b1, "R4 relocked", enable_o, 1);
    unlock(); wr(2'd1, 8'h00);
    chk(enable_o == 1'b0, "R12 disabled", enable_o, 0);
    idle(300, h);
    chk(h == 0, "R12 no request", h, 0);

    unlock(); wr(2'd1, 8'h80);
    until_req(n);
    chk(n >= LO && n <= HI, "R6 overflow timing", n, (LO + HI) / 2);
    chk(wd_flag_o && !enable_o, "R8 flag and enable", {wd_flag_o, enable_o}, 2);
    len = 0;
    while (rst_req_o && len < 50) begin len++; @(negedge sys_clk); end
    chk(len == HOLD, "R7 pulse width", len, HOLD);
    idle(300, h);
    chk(h == 0, "R8 no second overflow", h, 0);
    chk(wd_flag_o == 1'b1, "R8 flag sticky", wd_flag_o, 1);

    wr(2'd2, 8'h01);
    chk(wd_flag_o == 1'b1, "R10 write one keeps", wd_flag_o, 1);
    wr(2'd2, 8'h00);
    chk(wd_flag_o == 1'b0, "R10 write zero clears", wd_flag_o, 0);

    unlock(); wr(2'd1, 8'h80);
    h = 0;
    for (int k = 0; k < 20; k++) begin
      idle(20, n); h += n;
      unlock(); wr(2'd1, 8'h81);
    end
    chk(h == 0 && !rst_req_o, "R9 clears hold off reset", h, 0);
    chk(enable_o == 1'b1, "R9 enable kept", enable_o, 1);
    until_req(n);
    chk(n >= LO && n <= HI, "R9 restart from zero", n, (LO + HI) / 2);
    repeat (10) @(negedge sys_clk);

    chk(wd_flag_o == 1'b1, "R11 flag set before reset", wd_flag_o, 1);
    sys_rst_n = 1'b0;
    repeat (3) @(negedge sys_clk);
    sys_rst_n = 1'b1;
    @(negedge sys_clk);
    chk(wd_flag_o == 1'b0 && !enable_o, "R11 flag cleared", wd_flag_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule